// File: doc/BRIEF.md
# Sync Polarity Detector

This block watches the horizontal and vertical sync inputs of a video receiver and works out which level of each one is the active pulse. For HSYNC it counts the pixel clocks in one line and how many of them have the sync high. For VSYNC it does the same per frame, but counts lines instead of pixel clocks. A sync that is high for less than half of its period is reported as active-high. A sync that is high for half or more is reported as active-low. The measured period, the measured high width, the polarity flag and a valid flag are held in registers for a controller to read.

The block only reports. The controller reads the flags and then sets the timing generator's input polarity itself. Both inputs are asynchronous, so each one passes through a two-stage synchronizer before an edge detector. A measurement is latched at each synchronized rising edge. The valid flag rises once two complete periods have been measured. It clears again when no rising edge arrives within a programmable timeout.

Top module: `sync_polarity_detector`

## Requirements
- R1: During and directly after reset, every output is zero: both periods, both high widths, both polarity flags and both valid flags.
- R2: `hs_period` equals the number of pixel clocks between two successive rising edges of HSYNC. It is updated in the clock cycle after the synchronized rising edge (two synchronizer stages, then the edge detector).
- R3: `hs_high` equals the number of pixel clocks in that same interval during which synchronized HSYNC was high.
- R4: `hs_active_low` is 1 when twice the latched high width is at least the latched period, and 0 otherwise. An exact 50 % duty cycle therefore reads as active-low.
- R5: `hs_valid` becomes 1 at the third rising edge after reset or after a timeout, which is when two full lines have been measured. Before that edge it stays 0.
- R6: When H_TIMEOUT pixel clocks pass without an HSYNC rising edge, `hs_valid` drops to 0. The next two full lines are then needed before it returns to 1.
- R7: `vs_period` equals the number of HSYNC rising edges (lines) between two successive rising edges of VSYNC.
- R8: `vs_high` counts the lines in that interval during which VSYNC was high. `vs_active_low` follows the same rule as R4, applied to `vs_high` and `vs_period`.
- R9: `vs_valid` obeys the R5 and R6 rules, counted in lines and limited by V_TIMEOUT.
- R10: Periods, high widths and polarity flags change only in the cycle after a synchronized rising edge of their own sync. The block never drives any polarity configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Asynchronous horizontal sync |
| vsync_in | input | 1 | Asynchronous vertical sync |
| hs_period | output | HCNT_W | Line length in pixel clocks |
| hs_high | output | HCNT_W | HSYNC high time in pixel clocks |
| hs_active_low | output | 1 | HSYNC judged active-low |
| hs_valid | output | 1 | Horizontal measurement trustworthy |
| vs_period | output | VCNT_W | Frame length in lines |
| vs_high | output | VCNT_W | VSYNC high time in lines |
| vs_active_low | output | 1 | VSYNC judged active-low |
| vs_valid | output | 1 | Vertical measurement trustworthy |

## Verification
The properties assume three things about the inputs:
- Every sync period is shorter than its timeout.
- The counter widths can hold the longest period, so saturation never reaches a latched value.
- HSYNC keeps toggling whenever the vertical half is being judged, because lines are counted from its edges.

The stimulus therefore drives whole lines and frames whose sizes sit well below the bench's reduced timeouts. It stops HSYNC only in the horizontal timeout phase. In the vertical timeout phase it holds VSYNC while HSYNC keeps running. Input levels change only at falling clock edges.

// File: rtl/spd_pkg.sv
package spd_pkg;
  // Duty-cycle judgement: high width of half the period or more means the
  // pulse is the low part of the waveform.
  function automatic logic judge_active_low(input logic [31:0] high_w,
                                            input logic [31:0] period_w);
    return ({high_w, 1'b0} >= {1'b0, period_w});
  endfunction

  function automatic logic [31:0] sat_step(input logic [31:0] val,
                                           input logic [31:0] cap,
                                           input logic        inc);
    return (inc && (val != cap)) ? val + 32'd1 : val;
  endfunction
endpackage

// File: rtl/spd_sync_edge.sv
module spd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain[0] <= async_in;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      last <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~last;
endmodule

// File: rtl/spd_meter.sv
module spd_meter
  import spd_pkg::*;
#(
  parameter int W     = 12,
  parameter int LIMIT = 4000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         level,
  input  logic         rise,
  output logic [W-1:0] period_o,
  output logic [W-1:0] high_o,
  output logic         active_low_o,
  output logic         valid_o,
  output logic         timed_out_o
);
  localparam logic [W-1:0] CMAX = '1;
  localparam logic [W-1:0] LIM  = W'(LIMIT);

  logic [W-1:0] run_p, run_h, idle;
  logic [1:0]   edges;

  assign timed_out_o = (idle == LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_p        <= '0;
      run_h        <= '0;
      idle         <= '0;
      edges        <= '0;
      period_o     <= '0;
      high_o       <= '0;
      active_low_o <= 1'b0;
      valid_o      <= 1'b0;
    end else if (rise) begin
      if (edges != 2'd0) begin
        period_o     <= run_p;
        high_o       <= run_h;
        active_low_o <= judge_active_low(32'(run_h), 32'(run_p));
      end
      edges   <= (edges == 2'd3) ? edges : edges + 2'd1;
      valid_o <= (edges >= 2'd2);
      run_p   <= W'(tick);
      run_h   <= W'(tick);
      idle    <= '0;
    end else begin
      run_p <= W'(sat_step(32'(run_p), 32'(CMAX), tick));
      run_h <= W'(sat_step(32'(run_h), 32'(CMAX), tick & level));
      idle  <= W'(sat_step(32'(idle), 32'(LIM), tick));
      if (timed_out_o) begin
        edges   <= '0;
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sync_polarity_detector.sv
module sync_polarity_detector #(
  parameter int HCNT_W      = 12,
  parameter int VCNT_W      = 11,
  parameter int H_TIMEOUT   = 4000,
  parameter int V_TIMEOUT   = 1500,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_in,
  input  logic              vsync_in,
  output logic [HCNT_W-1:0] hs_period,
  output logic [HCNT_W-1:0] hs_high,
  output logic              hs_active_low,
  output logic              hs_valid,
  output logic [VCNT_W-1:0] vs_period,
  output logic [VCNT_W-1:0] vs_high,
  output logic              vs_active_low,
  output logic              vs_valid
);
  // Named internal events, visible to the bound checker.
  logic h_level, h_rise, v_level, v_rise;
  logic line_tick, h_timeout, v_timeout;

  spd_sync_edge #(.STAGES(SYNC_STAGES)) u_hs_in (
    .clk(clk), .rst_n(rst_n), .async_in(hsync_in),
    .level(h_level), .rise(h_rise)
  );

  spd_sync_edge #(.STAGES(SYNC_STAGES)) u_vs_in (
    .clk(clk), .rst_n(rst_n), .async_in(vsync_in),
    .level(v_level), .rise(v_rise)
  );

  // One line elapses per HSYNC rising edge.
  assign line_tick = h_rise;

  spd_meter #(.W(HCNT_W), .LIMIT(H_TIMEOUT)) u_h_meter (
    .clk(clk), .rst_n(rst_n), .tick(1'b1), .level(h_level), .rise(h_rise),
    .period_o(hs_period), .high_o(hs_high), .active_low_o(hs_active_low),
    .valid_o(hs_valid), .timed_out_o(h_timeout)
  );

  spd_meter #(.W(VCNT_W), .LIMIT(V_TIMEOUT)) u_v_meter (
    .clk(clk), .rst_n(rst_n), .tick(line_tick), .level(v_level), .rise(v_rise),
    .period_o(vs_period), .high_o(vs_high), .active_low_o(vs_active_low),
    .valid_o(vs_valid), .timed_out_o(v_timeout)
  );
endmodule

// File: rtl/sync_polarity_detector_checks.sv
module spd_checks #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_rise,
  input logic          v_rise,
  input logic          h_timeout,
  input logic          v_timeout,
  input logic [HW-1:0] h_period,
  input logic [HW-1:0] h_high,
  input logic          h_low,
  input logic          h_valid,
  input logic [VW-1:0] v_period,
  input logic [VW-1:0] v_high,
  input logic          v_low,
  input logic          v_valid
);
  a_r10_h_period_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !h_rise |=> $stable(h_period));
  a_r10_h_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !h_rise |=> $stable(h_high) && $stable(h_low));
  a_r3_h_high_within: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid |-> h_high <= h_period);
  a_r4_h_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid |-> (h_low == ({h_high, 1'b0} >= {1'b0, h_period})));
  a_r5_h_valid_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_valid) |-> $past(h_rise));
  a_r6_h_timeout_clears: assert property (@(posedge clk) disable iff (!rst_n)
    h_timeout && !h_rise |=> !h_valid);
  a_r7_v_period_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !v_rise |=> $stable(v_period) && $stable(v_high) && $stable(v_low));
  a_r8_v_high_within: assert property (@(posedge clk) disable iff (!rst_n)
    v_valid |-> v_high <= v_period);
  a_r9_v_valid_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(v_valid) |-> $past(v_rise));
  a_r9_v_timeout_clears: assert property (@(posedge clk) disable iff (!rst_n)
    v_timeout && !v_rise |=> !v_valid);
endmodule

bind sync_polarity_detector spd_checks #(.HW(HCNT_W), .VW(VCNT_W)) u_spd_checks (
  .clk(clk), .rst_n(rst_n), .h_rise(h_rise), .v_rise(v_rise),
  .h_timeout(h_timeout), .v_timeout(v_timeout),
  .h_period(hs_period), .h_high(hs_high), .h_low(hs_active_low), .h_valid(hs_valid),
  .v_period(vs_period), .v_high(vs_high), .v_low(vs_active_low), .v_valid(vs_valid)
);

// File: tb/sync_polarity_detector_test.sv
`timescale 1ns/1ps
module sync_polarity_detector_test;
  localparam int HW = 12, VW = 11, HTO = 200, VTO = 30;

  logic clk = 1'b0, rst_n = 1'b0, hsync_in = 1'b0, vsync_in = 1'b0;
  logic [HW-1:0] hs_period, hs_high;
  logic [VW-1:0] vs_period, vs_high;
  logic hs_active_low, hs_valid, vs_active_low, vs_valid;

  int errors = 0, checks = 0;

  sync_polarity_detector #(.HCNT_W(HW), .VCNT_W(VW), .H_TIMEOUT(HTO),
                           .V_TIMEOUT(VTO)) uut (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .hs_period(hs_period), .hs_high(hs_high), .hs_active_low(hs_active_low),
    .hs_valid(hs_valid), .vs_period(vs_period), .vs_high(vs_high),
    .vs_active_low(vs_active_low), .vs_valid(vs_valid)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: one measurement channel as integers.
  typedef struct {
    int run_len, run_hi, quiet, seen, per, hi, low, ok;
  } chan_t;

  function automatic chan_t advance(chan_t s, bit tick, bit lvl, bit edge_now,
                                    int lim, int cap);
    chan_t n = s;
    if (edge_now) begin
      if (s.seen > 0) begin
        n.per = s.run_len;
        n.hi  = s.run_hi;
        n.low = (2 * s.run_hi >= s.run_len) ? 1 : 0;
      end
      n.ok      = (s.seen >= 2) ? 1 : 0;
      n.seen    = (s.seen < 3) ? s.seen + 1 : 3;
      n.run_len = tick;
      n.run_hi  = tick;
      n.quiet   = 0;
    end else begin
      if (tick) begin
        n.run_len = (s.run_len < cap) ? s.run_len + 1 : cap;
        if (lvl) n.run_hi = (s.run_hi < cap) ? s.run_hi + 1 : cap;
        n.quiet = (s.quiet < lim) ? s.quiet + 1 : lim;
      end
      if (s.quiet == lim) begin
        n.seen = 0;
        n.ok   = 0;
      end
    end
    return n;
  endfunction

  chan_t mh, mv;
  bit hq[$], vq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      mh = '{default: 0};
      mv = '{default: 0};
      hq = '{0, 0, 0, 0};
      vq = '{0, 0, 0, 0};
    end else begin
      bit hl, hr, vl, vr;
      hq.push_front(hsync_in); void'(hq.pop_back());
      vq.push_front(vsync_in); void'(vq.pop_back());
      hl = hq[2]; hr = hq[2] & ~hq[3];
      vl = vq[2]; vr = vq[2] & ~vq[3];
      mh = advance(mh, 1'b1, hl, hr, HTO, (1 << HW) - 1);
      mv = advance(mv, hr, vl, vr, VTO, (1 << VW) - 1);
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(hs_period) == mh.per, "R2/R10 hs_period", int'(hs_period), mh.per);
      chk(int'(hs_high) == mh.hi, "R3/R10 hs_high", int'(hs_high), mh.hi);
      chk(int'(hs_active_low) == mh.low, "R4 hs_active_low", int'(hs_active_low), mh.low);
      chk(int'(hs_valid) == mh.ok, "R5/R6 hs_valid", int'(hs_valid), mh.ok);
      chk(int'(vs_period) == mv.per, "R7 vs_period", int'(vs_period), mv.per);
      chk(int'(vs_high) == mv.hi, "R8 vs_high", int'(vs_high), mv.hi);
      chk(int'(vs_active_low) == mv.low, "R8 vs_active_low", int'(vs_active_low), mv.low);
      chk(int'(vs_valid) == mv.ok, "R9 vs_valid", int'(vs_valid), mv.ok);
    end
  end

  task automatic run_video(input int len, input int hw, input int lines,
                           input int vh, input int frames);
    for (int f = 0; f < frames; f++)
      for (int ln = 0; ln < lines; ln++)
        for (int px = 0; px < len; px++) begin
          @(negedge clk);
          hsync_in = (px < hw);
          vsync_in = (ln < vh);
        end
  endtask

  task automatic expect_h(input int len, input int hw, input int low);
    chk(int'(hs_period) == len, "R2 line length", int'(hs_period), len);
    chk(int'(hs_high) == hw, "R3 high width", int'(hs_high), hw);
    chk(int'(hs_active_low) == low, "R4 polarity", int'(hs_active_low), low);
    chk(hs_valid == 1'b1, "R5 valid", int'(hs_valid), 1);
  endtask

  task automatic expect_v(input int lines, input int vh, input int low);
    chk(int'(vs_period) == lines, "R7 frame length", int'(vs_period), lines);
    chk(int'(vs_high) == vh, "R8 high lines", int'(vs_high), vh);
    chk(int'(vs_active_low) == low, "R8 polarity", int'(vs_active_low), low);
    chk(vs_valid == 1'b1, "R9 valid", int'(vs_valid), 1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog R1..: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs are all zero while in reset
    chk({hs_period, hs_high, hs_active_low, hs_valid, vs_period, vs_high,
         vs_active_low, vs_valid} == '0, "R1 reset state", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({hs_period, hs_high, hs_active_low, hs_valid, vs_period, vs_high,
         vs_active_low, vs_valid} == '0, "R1 after reset", 0, 0);

    // Narrow positive pulses on both syncs
    run_video(40, 6, 12, 2, 4);
    expect_h(40, 6, 0);
    expect_v(12, 2, 0);

    // Wide high phase: active-low on both
    run_video(40, 34, 12, 10, 4);
    expect_h(40, 34, 1);
    expect_v(12, 10, 1);

    // Exact half duty cycle reads as active-low
    run_video(30, 15, 10, 5, 4);
    expect_h(30, 15, 1);
    expect_v(10, 5, 1);

    // R6: HSYNC stops for longer than the timeout
    hsync_in = 1'b0;
    vsync_in = 1'b0;
    repeat (HTO + 20) @(negedge clk);
    chk(hs_valid == 1'b0, "R6 timeout clears hs_valid", int'(hs_valid), 0);
    chk(int'(hs_period) == 30, "R10 period held after timeout", int'(hs_period), 30);

    // R5: one line after a timeout is not enough
    run_video(40, 6, 1, 0, 1);
    chk(hs_valid == 1'b0, "R5 not valid after one edge", int'(hs_valid), 0);
    run_video(40, 6, 3, 0, 1);
    expect_h(40, 6, 0);

    // R9: VSYNC held low while lines keep coming
    run_video(40, 6, VTO + 5, 0, 1);
    chk(vs_valid == 1'b0, "R9 timeout clears vs_valid", int'(vs_valid), 0);
    chk(hs_valid == 1'b1, "R6 hs_valid unaffected", int'(hs_valid), 1);

    // Recovery of both halves
    run_video(36, 4, 14, 3, 4);
    expect_h(36, 4, 0);
    expect_v(14, 3, 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule